// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that software controls through a small memory-mapped register set. Software writes an output value and a per-pin direction. The block drives the pad outputs and the output enables from those two registers. The pads themselves are sampled through a two-flop synchronizer. Their settled levels can be read from a pad-status register, which is separate from the written output value.

Each pin has a two-bit condition selector. The selector picks one of four conditions: low level, high level, rising edge or falling edge. A pin whose condition occurs latches a bit in a sticky status register, whether or not that pin is enabled. Software clears a status bit by writing 1 to it. A mask register chooses which latched bits reach the single port interrupt line.

The register interface has a write port (address, data, strobe) and a combinational read port (address in, data out). A write takes effect at the next rising clock edge.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset (rst_n low) is applied, the output value, direction, both condition, mask and status registers all read as zero, pad_oe is zero and irq is low.
- R2: The output value register at offset 0x00 reads back the last value written to it and drives pad_out. The direction register at offset 0x04 reads back likewise and drives pad_oe, where 1 = output. Both take effect from the clock edge that commits the write.
- R3: Offset 0x08 returns pad_in after two synchronizer flops. A pad change driven between edges is visible after the second following rising edge and not after the first. Writes to 0x08 are ignored. The value written at 0x00 never appears at 0x08.
- R4: Condition fields are 2 bits wide. Pins 0 to 15 use the register at 0x0C and pins 16 to 31 use the register at 0x10. Pin p uses bits [2*(p mod 16)+1 : 2*(p mod 16)]. The encodings are 00 = low level, 01 = high level, 10 = rising edge and 11 = falling edge. Both condition registers read back what was written.
- R5: A pin's status bit at 0x18 is set at the third rising edge after a matching pad change, and it is not yet set at the second. Edge modes compare the current synchronized sample with the previous one. The bit is set regardless of the mask, and it stays set until it is cleared.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A condition that is present in the same cycle as the clear wins, so a level that is still present keeps the bit set.
- R7: The mask register at 0x14 has 1 = enabled. irq is the OR over all pins of (status AND mask), and it follows the registers with no extra delay.
- R8: Reads of any unmapped offset (0x1C to 0x1F, and addresses that are not multiples of 4 within the map) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined port interrupt |

## Verification
- **Register writes:** a register write is visible on the read port and on pad_out or pad_oe from the committing edge. The bench therefore reads half a cycle after that edge.
- **Pad status:** the pad status is due two edges after a pad change. The bench drives pads on the falling edge and reads once after one edge and once after two, to pin down that latency.
- **Status bits:** status bits are due on the third edge, and irq follows in the same cycle. The directed cases read just before and just after that edge.
- **Random phase:** each random round holds its pad values for four cycles before it clears or reads. All edge events have then settled, and the expected status follows from the old and new pad words alone.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        COND_LOW  = 2'b00,
        COND_HIGH = 2'b01,
        COND_RISE = 2'b10,
        COND_FALL = 2'b11
    } cond_e;

    localparam int OFF_DATA   = 'h00;
    localparam int OFF_DIR    = 'h04;
    localparam int OFF_PAD    = 'h08;
    localparam int OFF_CFG_LO = 'h0C;
    localparam int OFF_CFG_HI = 'h10;
    localparam int OFF_MASK   = 'h14;
    localparam int OFF_STAT   = 'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cond_detect.sv
module gpio_cond_detect import gpio_pkg::*; #(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*NPIN-1:0] cond_bus,
    input  logic [NPIN-1:0]   sync_in,
    output logic [NPIN-1:0]   event_out
);
    logic [NPIN-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        cond_e sel;
        assign sel = cond_e'(cond_bus[2*g +: 2]);
        always_comb begin
            unique case (sel)
                COND_LOW:  event_out[g] = ~sync_in[g];
                COND_HIGH: event_out[g] =  sync_in[g];
                COND_RISE: event_out[g] =  sync_in[g] & ~prev_q[g];
                COND_FALL: event_out[g] = ~sync_in[g] &  prev_q[g];
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port import gpio_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe,
    output logic              irq
);
    localparam int NPIN = DATA_W;
    localparam int HALF = NPIN / 2;
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_PAD    = ADDR_W'(OFF_PAD);
    localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(OFF_CFG_LO);
    localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(OFF_CFG_HI);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);

    logic [DATA_W-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, status_q;
    logic [NPIN-1:0]   pad_sync, event_vec, clr_vec;
    logic [2*NPIN-1:0] cond_bus;

    gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar g = 0; g < HALF; g++) begin : g_cfg
        assign cond_bus[2*g +: 2]        = cfg_lo_q[2*g +: 2];
        assign cond_bus[2*(g+HALF) +: 2] = cfg_hi_q[2*g +: 2];
    end

    gpio_cond_detect #(.NPIN(NPIN)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_bus  (cond_bus),
        .sync_in   (pad_sync),
        .event_out (event_vec)
    );

    assign clr_vec = (wr_en && wr_addr == A_STAT) ? wr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_DATA)   data_q   <= wr_data;
            if (wr_en && wr_addr == A_DIR)    dir_q    <= wr_data;
            if (wr_en && wr_addr == A_CFG_LO) cfg_lo_q <= wr_data;
            if (wr_en && wr_addr == A_CFG_HI) cfg_hi_q <= wr_data;
            if (wr_en && wr_addr == A_MASK)   mask_q   <= wr_data;
            status_q <= (status_q & ~clr_vec) | event_vec;
        end
    end

    always_comb begin
        case (rd_addr)
            A_DATA:   rd_data = data_q;
            A_DIR:    rd_data = dir_q;
            A_PAD:    rd_data = pad_sync;
            A_CFG_LO: rd_data = cfg_lo_q;
            A_CFG_HI: rd_data = cfg_hi_q;
            A_MASK:   rd_data = mask_q;
            A_STAT:   rd_data = status_q;
            default:  rd_data = '0;
        endcase
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign irq     = |(status_q & mask_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] pad_oe,
    input logic              irq,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] event_vec
);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(gpio_pkg::OFF_DIR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(gpio_pkg::OFF_STAT);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!irq && pad_oe == '0)); // R1

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIR) |=> (pad_oe == $past(wr_data))); // R2

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(event_vec)) == $past(event_vec))); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_STAT)
        |=> ((status_q & $past(wr_data) & ~$past(event_vec)) == '0)); // R6

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0)); // R7
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .event_vec (event_vec)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] lo, input logic [31:0] hi,
                                               input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            logic [1:0] f;
            f = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
            case (f)
                2'b00:   r[i] = ~a[i] | ~b[i];
                2'b01:   r[i] =  a[i] |  b[i];
                2'b10:   r[i] = ~a[i] &  b[i];
                default: r[i] =  a[i] & ~b[i];
            endcase
        end
        return r;
    endfunction

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, pa, pb, lo, hi, mk, dd, dr, es;
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        idle(2);
        foreach (v[i]) ; // no-op
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 reset pad_oe", pad_oe, 32'h0);
        check("R1 reset irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R8: unmapped offsets
        rd(5'h1C, v); check("R8 unmapped 0x1C", v, 32'h0);
        rd(5'h05, v); check("R8 unmapped 0x05", v, 32'h0);

        // R2: output value and direction
        wr(5'h00, 32'hA5A5_0F0F);
        rd(5'h00, v); check("R2 data readback", v, 32'hA5A5_0F0F);
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        rd(5'h04, v); check("R2 dir readback", v, 32'hFFFF_0000);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(5'h08, v); check("R3 data not on pad status", v, 32'h0);

        // R3: pad status latency and write ignore
        pad_in = 32'h1234_5678;
        idle(1);
        rd(5'h08, v); check("R3 pad status after one edge", v, 32'h0);
        idle(1);
        rd(5'h08, v); check("R3 pad status after two edges", v, 32'h1234_5678);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v); check("R3 pad status write ignored", v, 32'h1234_5678);

        // R4: condition registers
        wr(5'h0C, 32'hAAAA_AAAA);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h0C, v); check("R4 cfg low readback", v, 32'hAAAA_AAAA);
        rd(5'h10, v); check("R4 cfg high readback", v, 32'hFFFF_FFFF);

        // R6: clear all with edge modes and stable pads
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); check("R6 clear all", v, 32'h0);

        // R5: rising on pin 0, falling on pin 28, third-edge timing
        pad_in = 32'h0234_5679;
        idle(2);
        rd(5'h18, v); check("R5 status not yet at second edge", v, 32'h0);
        idle(1);
        rd(5'h18, v); check("R5 status at third edge", v, 32'h1000_0001);
        check("R7 irq low with mask zero", {31'b0, irq}, 32'h0);
        wr(5'h14, 32'h0000_0001);
        check("R7 irq via pin 0", {31'b0, irq}, 32'h1);
        wr(5'h14, 32'h0000_0002);
        check("R7 irq off for other pin", {31'b0, irq}, 32'h0);
        wr(5'h18, 32'h0);
        rd(5'h18, v); check("R6 write zero keeps status", v, 32'h1000_0001);
        wr(5'h18, 32'h1);
        rd(5'h18, v); check("R6 clear single bit", v, 32'h1000_0000);

        // R6: level present during clear wins (pin 0 high mode, pad high)
        wr(5'h0C, 32'hAAAA_AAA9);
        idle(1);
        wr(5'h18, 32'h1);
        rd(5'h18, v); check("R6 level beats clear", v, 32'h1000_0001);
        pad_in = 32'h0234_5678;
        idle(3);
        wr(5'h18, 32'h1);
        idle(1);
        rd(5'h18, v); check("R6 level gone stays clear", v, 32'h1000_0000);

        // R4: upper field position, pin 17 high mode at bits [3:2]
        wr(5'h10, 32'hFFFF_FFF7);
        pad_in = 32'h0236_5678;
        idle(3);
        wr(5'h18, 32'h0002_0000);
        rd(5'h18, v); check("R4 pin 17 field selects high level", v, 32'h1002_0000);
        wr(5'h14, 32'h0002_0000);
        check("R7 irq via pin 17", {31'b0, irq}, 32'h1);

        // Random rounds
        for (int it = 0; it < 40; it++) begin
            lo = $urandom; hi = $urandom; mk = $urandom;
            pa = $urandom; pb = $urandom; dd = $urandom; dr = $urandom;
            wr(5'h00, dd);
            wr(5'h04, dr);
            check("R2 random pad_out", pad_out, dd);
            check("R2 random pad_oe", pad_oe, dr);
            wr(5'h0C, lo);
            wr(5'h10, hi);
            wr(5'h14, mk);
            pad_in = pa;
            idle(4);
            rd(5'h08, v); check("R3 random pad status", v, pa);
            wr(5'h18, 32'hFFFF_FFFF);
            pad_in = pb;
            idle(4);
            es = exp_status(lo, hi, pa, pb);
            rd(5'h18, v); check("R5 random status", v, es);
            check("R7 random irq", {31'b0, irq}, {31'b0, |(es & mk)});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule